// File: doc/BRIEF.md
# Serial Interrupt Slave Agent

This block is the device-side agent for the single-wire serialized interrupt protocol used on PCI-era systems. It runs on the 33 MHz PCI clock. It watches the shared open-drain interrupt line and counts three-clock frames from the end of each Start pulse. In the frame that belongs to each local interrupt, it reports that interrupt's level. A local interrupt `n` owns frame `n`. When the interrupt is asserted, the agent pulls the line low for the sample clock of that frame, drives it high for one clock, and then releases it.

The host ends every cycle with a Stop pulse. The width of that pulse selects the mode for the next cycle. In quiet mode the agent may open a cycle by itself: when a local level changes while the bus is idle, it pulls the line low for one clock and the host then extends the Start Frame. In continuous mode only the host starts cycles. The agent never produces a Stop pulse.

The line is split into a sampled input, a data output and an output enable. Board logic or an I/O pad combines them into the wired line.

Top module: `sirq_agent`

## Requirements
- R1: After a synchronous active-high reset, `sirq_oe` is 0 and the agent is in continuous mode, so it does not start cycles by itself.
- R2: A Start Frame is any low run seen while idle. The first high clock after that run is followed by one turnaround clock. Frame `n` then has its sample clock at 2+3n clocks after that first high clock, followed by its recovery clock and its turnaround clock.
- R3: In the sample clock of frame `n` (n < NUM_IRQ), the line is driven low when `irq_lvl_in[n]` is 1 (active high) and is left released when it is 0.
- R4: After a low sample drive, the agent drives the line high (`sirq_oe`=1, `sirq_out`=1) for exactly the recovery clock and releases it in the turnaround clock.
- R5: Sample clocks of frames numbered NUM_IRQ or higher are never driven.
- R6: While frames are being counted, a low run of exactly 2 clocks is a Stop Frame that selects quiet mode. A run of 3 or more clocks selects continuous mode. The mode is latched when the line returns high and holds until the next Stop Frame.
- R7: In quiet mode with the bus idle, a change of any local level presented at clock T makes the agent drive the line low in clock T+3, for one clock only. It releases the line in T+4.
- R8: In continuous mode the agent never starts a cycle, whatever the local levels do.
- R9: A local level change that arrives during an active cycle in quiet mode is remembered. The agent then starts a new cycle 2 clocks after the first high clock that ends the Stop Frame.
- R10: The agent drives the line low only in its own one-clock start pulse or in a sample clock; it never drives a Stop Frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lvl_in | input | NUM_IRQ | Local interrupt levels, active high; bit n reports in frame n |
| sirq_in | input | 1 | Sampled level of the shared serial interrupt line |
| sirq_out | output | 1 | Value driven onto the line when enabled |
| sirq_oe | output | 1 | Output enable for the line driver |

## Verification
Two functions can land in the same cycle: a local level change and the host's Stop Frame. A change that lands there can be lost, or it can produce a start pulse that overlaps the host's stop. The bench provokes this by changing the levels on the first low clock of a 2-clock stop. It then expects the line to stay high in the clock after the stop ends, and to be pulled low by the agent in the clock after that. It also sweeps every level pattern of a 4-interrupt configuration through full host-driven cycles, so that each sample, recovery and turnaround clock is compared against the pattern.

// File: rtl/sirq_agent_pkg.sv
package sirq_agent_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE   = 2'd0,
    BUS_START  = 2'd1,
    BUS_FRAMES = 2'd2
  } bus_state_e;

  typedef enum logic [1:0] {
    PH_SAMPLE  = 2'd0,
    PH_RECOVER = 2'd1,
    PH_TURN    = 2'd2
  } phase_e;

endpackage

// File: rtl/sirq_input_stage.sv
module sirq_input_stage #(
  parameter int NUM_IRQ = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_raw,
  output logic [NUM_IRQ-1:0] irq_lvl,
  output logic               irq_changed
);

  logic [NUM_IRQ-1:0] irq_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lvl  <= '0;
      irq_prev <= '0;
    end else begin
      irq_lvl  <= irq_raw;
      irq_prev <= irq_lvl;
    end
  end

  assign irq_changed = |(irq_lvl ^ irq_prev);

endmodule

// File: rtl/sirq_frame_tracker.sv
module sirq_frame_tracker
  import sirq_agent_pkg::*;
#(
  parameter int MAX_FRAMES = 32,
  parameter int SLOT_W     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line,
  output bus_state_e        state_q,
  output bus_state_e        state_d,
  output phase_e            phase_q,
  output phase_e            phase_d,
  output logic [SLOT_W-1:0] slot_q,
  output logic [SLOT_W-1:0] slot_d,
  output logic              quiet_q,
  output logic              rise
);

  localparam logic [SLOT_W-1:0] SLOT_MAX = SLOT_W'(MAX_FRAMES);

  logic [1:0] lowrun_q, lowrun_d;
  logic       quiet_d;

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    slot_d   = slot_q;
    lowrun_d = lowrun_q;
    quiet_d  = quiet_q;
    rise     = 1'b0;
    case (state_q)
      BUS_IDLE: begin
        if (!line) state_d = BUS_START;
      end
      BUS_START: begin
        if (line) begin
          rise     = 1'b1;
          state_d  = BUS_FRAMES;
          phase_d  = PH_TURN;
          slot_d   = '0;
          lowrun_d = '0;
        end
      end
      BUS_FRAMES: begin
        case (phase_q)
          PH_SAMPLE: begin
            phase_d = PH_RECOVER;
            if (slot_q != SLOT_MAX) slot_d = slot_q + 1'b1;
          end
          PH_RECOVER: phase_d = PH_TURN;
          default:    phase_d = PH_SAMPLE;
        endcase
        if (!line) begin
          if (lowrun_q != 2'd3) lowrun_d = lowrun_q + 2'd1;
        end else begin
          lowrun_d = '0;
          if (lowrun_q >= 2'd2) begin
            state_d = BUS_IDLE;
            quiet_d = (lowrun_q == 2'd2);
          end
        end
      end
      default: state_d = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= BUS_IDLE;
      phase_q  <= PH_TURN;
      slot_q   <= '0;
      lowrun_q <= '0;
      quiet_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      slot_q   <= slot_d;
      lowrun_q <= lowrun_d;
      quiet_q  <= quiet_d;
    end
  end

endmodule

// File: rtl/sirq_start_request.sv
module sirq_start_request (
  input  logic clk,
  input  logic rst,
  input  logic bus_idle,
  input  logic quiet,
  input  logic line,
  input  logic irq_changed,
  input  logic rise,
  output logic start_go
);

  logic pending_q;

  always_ff @(posedge clk) begin
    if (rst)              pending_q <= 1'b0;
    else if (irq_changed) pending_q <= 1'b1;
    else if (rise)        pending_q <= 1'b0;
  end

  assign start_go = bus_idle && quiet && pending_q && line;

endmodule

// File: rtl/sirq_slot_driver.sv
module sirq_slot_driver
  import sirq_agent_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int SLOT_W  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frames_d,
  input  phase_e             phase_d,
  input  logic [SLOT_W-1:0]  slot_d,
  input  logic [NUM_IRQ-1:0] irq_lvl,
  input  logic               start_go,
  output logic               sirq_out,
  output logic               sirq_oe
);

  logic sel_lvl;
  logic drive_low_d, drive_high_d;
  logic drove_q;

  always_comb begin
    sel_lvl = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (slot_d == SLOT_W'(i)) sel_lvl = irq_lvl[i];
    end
  end

  assign drive_low_d  = frames_d && (phase_d == PH_SAMPLE) && sel_lvl;
  assign drive_high_d = frames_d && (phase_d == PH_RECOVER) && drove_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sirq_oe  <= 1'b0;
      sirq_out <= 1'b1;
      drove_q  <= 1'b0;
    end else begin
      drove_q <= drive_low_d && !start_go;
      if (start_go || drive_low_d) begin
        sirq_oe  <= 1'b1;
        sirq_out <= 1'b0;
      end else if (drive_high_d) begin
        sirq_oe  <= 1'b1;
        sirq_out <= 1'b1;
      end else begin
        sirq_oe  <= 1'b0;
        sirq_out <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sirq_agent.sv
module sirq_agent
  import sirq_agent_pkg::*;
#(
  parameter int NUM_IRQ    = 16,
  parameter int MAX_FRAMES = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_lvl_in,
  input  logic               sirq_in,
  output logic               sirq_out,
  output logic               sirq_oe
);

  localparam int SLOT_W = $clog2(MAX_FRAMES + 1);

  logic [NUM_IRQ-1:0] irq_lvl;
  logic               irq_changed;
  bus_state_e         cur_state, nxt_state;
  phase_e             cur_phase, nxt_phase;
  logic [SLOT_W-1:0]  cur_slot, nxt_slot;
  logic               quiet_mode;
  logic               rise;
  logic               start_go;

  sirq_input_stage #(.NUM_IRQ(NUM_IRQ)) u_inp (
    .clk         (clk),
    .rst         (rst),
    .irq_raw     (irq_lvl_in),
    .irq_lvl     (irq_lvl),
    .irq_changed (irq_changed)
  );

  sirq_frame_tracker #(.MAX_FRAMES(MAX_FRAMES), .SLOT_W(SLOT_W)) u_trk (
    .clk     (clk),
    .rst     (rst),
    .line    (sirq_in),
    .state_q (cur_state),
    .state_d (nxt_state),
    .phase_q (cur_phase),
    .phase_d (nxt_phase),
    .slot_q  (cur_slot),
    .slot_d  (nxt_slot),
    .quiet_q (quiet_mode),
    .rise    (rise)
  );

  sirq_start_request u_req (
    .clk         (clk),
    .rst         (rst),
    .bus_idle    (cur_state == BUS_IDLE),
    .quiet       (quiet_mode),
    .line        (sirq_in),
    .irq_changed (irq_changed),
    .rise        (rise),
    .start_go    (start_go)
  );

  sirq_slot_driver #(.NUM_IRQ(NUM_IRQ), .SLOT_W(SLOT_W)) u_drv (
    .clk      (clk),
    .rst      (rst),
    .frames_d (nxt_state == BUS_FRAMES),
    .phase_d  (nxt_phase),
    .slot_d   (nxt_slot),
    .irq_lvl  (irq_lvl),
    .start_go (start_go),
    .sirq_out (sirq_out),
    .sirq_oe  (sirq_oe)
  );

endmodule

// File: rtl/sirq_agent_chk.sv
module sirq_agent_chk
  import sirq_agent_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int SLOT_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              sirq_out,
  input logic              sirq_oe,
  input bus_state_e        state,
  input phase_e            phase,
  input logic [SLOT_W-1:0] slot,
  input logic              quiet
);

  // R4
  recover_high_chk: assert property (@(posedge clk) disable iff (rst)
    (sirq_oe && !sirq_out && state == BUS_FRAMES) |=> (sirq_oe && sirq_out));

  // R4
  release_after_high_chk: assert property (@(posedge clk) disable iff (rst)
    (sirq_oe && sirq_out) |=> !sirq_oe);

  // R5
  spare_slot_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == BUS_FRAMES && phase == PH_SAMPLE && slot >= SLOT_W'(NUM_IRQ)) |-> !sirq_oe);

  // R8
  cont_no_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state == BUS_IDLE && !quiet) |=> !(sirq_oe && !sirq_out));

  // R10
  low_drive_place_chk: assert property (@(posedge clk) disable iff (rst)
    (sirq_oe && !sirq_out) |-> ((state == BUS_FRAMES && phase == PH_SAMPLE) || state == BUS_IDLE));

endmodule

bind sirq_agent sirq_agent_chk #(.NUM_IRQ(NUM_IRQ), .SLOT_W(SLOT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sirq_out (sirq_out),
  .sirq_oe  (sirq_oe),
  .state    (cur_state),
  .phase    (cur_phase),
  .slot     (cur_slot),
  .quiet    (quiet_mode)
);

// File: tb/sirq_agent_bench.sv
`timescale 1ns/1ps
module sirq_agent_bench;

  localparam int NI = 4;
  localparam int MF = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [NI-1:0] irq;
  logic          host_n;
  logic          dev_o, dev_oe;
  logic          line;
  int            checks = 0;
  int            fails = 0;

  always #4 clk = ~clk;

  assign line = host_n & (dev_oe ? dev_o : 1'b1);

  sirq_agent #(.NUM_IRQ(NI), .MAX_FRAMES(MF)) u_sirq_agent (
    .clk        (clk),
    .rst        (rst),
    .irq_lvl_in (irq),
    .sirq_in    (line),
    .sirq_out   (dev_o),
    .sirq_oe    (dev_oe)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic hv);
    @(negedge clk);
    host_n = hv;
    #1;
  endtask

  task automatic tick_irq(input logic hv, input logic [NI-1:0] v);
    @(negedge clk);
    host_n = hv;
    irq = v;
    #1;
  endtask

  task automatic host_start(input int len);
    for (int i = 0; i < len; i++) tick(1'b0);
    tick(1'b1);
    chk("R2 first high", line, 1'b1);
  endtask

  task automatic frames_stop(input logic [NI-1:0] pat, input int nfr, input int stop_len,
                             input bit chg_en, input logic [NI-1:0] chg_pat);
    tick(1'b1);
    chk("R2 start turnaround", dev_oe, 1'b0);
    for (int n = 0; n < nfr; n++) begin
      logic drv;
      drv = 1'b0;
      if (n < NI) drv = pat[n];
      tick(1'b1);
      if (n < NI) chk("R3 sample", line, ~drv);
      else        chk("R5 spare slot", dev_oe, 1'b0);
      tick(1'b1);
      chk("R4 recovery oe", dev_oe, drv);
      if (drv) chk("R4 recovery high", dev_o, 1'b1);
      tick(1'b1);
      chk("R4 turnaround", dev_oe, 1'b0);
    end
    for (int s = 0; s < stop_len; s++) begin
      if (s == 0 && chg_en) tick_irq(1'b0, chg_pat);
      else                  tick(1'b0);
      chk("R10 no stop drive", dev_oe, 1'b0);
    end
    tick(1'b1);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    host_n = 1'b1;
    irq = '0;
    repeat (4) @(negedge clk);
    chk("R1 reset oe", dev_oe, 1'b0);
    rst = 1'b0;

    // R1 / R8: continuous after reset, a level change starts nothing
    tick_irq(1'b1, 4'b0001);
    for (int i = 0; i < 8; i++) begin tick(1'b1); chk("R8 no self start", line, 1'b1); end

    // R2 R3 R4 R5: every level pattern through a host cycle
    for (int p = 0; p < (1 << NI); p++) begin
      tick_irq(1'b1, p[NI-1:0]);
      repeat (3) tick(1'b1);
      host_start(4);
      frames_stop(p[NI-1:0], 6, 3, 1'b0, '0);
      for (int i = 0; i < 2; i++) begin tick(1'b1); chk("R8 idle", line, 1'b1); end
    end

    // R6: 2-clock stop -> quiet
    tick_irq(1'b1, '0);
    repeat (3) tick(1'b1);
    host_start(5);
    frames_stop('0, 6, 2, 1'b0, '0);
    for (int i = 0; i < 4; i++) begin tick(1'b1); chk("R7 no change no start", line, 1'b1); end

    // R7: change at T -> low at T+3, released at T+4
    tick_irq(1'b1, 4'b1010);
    chk("R7 T", line, 1'b1);
    tick(1'b1); chk("R7 T+1", line, 1'b1);
    tick(1'b1); chk("R7 T+2", line, 1'b1);
    tick(1'b1); chk("R7 T+3 low", line, 1'b0); chk("R7 T+3 oe", dev_oe, 1'b1);
    tick(1'b0); chk("R7 T+4 release", dev_oe, 1'b0);
    tick(1'b0); tick(1'b0);
    tick(1'b1); chk("R2 rise after self start", line, 1'b1);
    // R9: change on first stop clock
    frames_stop(4'b1010, 6, 2, 1'b1, 4'b0110);
    tick(1'b1); chk("R9 E+1 high", line, 1'b1);
    tick(1'b1); chk("R9 E+2 low", line, 1'b0); chk("R9 E+2 oe", dev_oe, 1'b1);
    tick(1'b0); tick(1'b0); tick(1'b0);
    tick(1'b1);
    frames_stop(4'b0110, 6, 3, 1'b0, '0);

    // R6: 3-clock stop -> continuous, latched
    tick_irq(1'b1, 4'b1111);
    for (int i = 0; i < 8; i++) begin tick(1'b1); chk("R6 continuous latched", line, 1'b1); end
    host_start(4);
    frames_stop(4'b1111, 5, 2, 1'b0, '0);
    tick_irq(1'b1, '0);
    tick(1'b1); tick(1'b1);
    tick(1'b1); chk("R6 quiet latched start", line, 1'b0);
    tick(1'b0); chk("R6 release", dev_oe, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule